// File: doc/BRIEF.md
# SPI Memory Command and Write-Protection Controller

This block is the command decoder and protection logic of a small SPI serial memory slave. The memory holds 512 bytes with 9-bit addresses. The block watches chip select, serial clock and MOSI, decodes the opcodes and keeps a status register. The status register holds a write-enable latch and two block-protect bits. Memory accesses go to an internal byte RAM.

Every memory byte that arrives during a write command passes through a write-permit check before it reaches the RAM. The check requires three things: the hardware protect pin is high, the latch is armed, and the address lies outside the range selected by the protect bits. The status register is read back on MISO, and its protect bits can be rewritten under the same pin and latch rules.

All SPI pins are sampled through synchronizers in the system clock domain. The serial clock must therefore run well below the system clock. Transfers use SPI mode 0 with the most significant bit first.

Top module: `spiwp_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00: latch clear and both protect bits clear, so the whole array is writable once the latch is armed. MISO is 0 while chip select is high.
- R2: The status byte returned by opcode 0x05 has the protect bits at bit 3 (upper) and bit 2 (lower) and the latch at bit 1. Bits 7..4 and bit 0 always read 0, whatever value was written. The status byte is shifted out MSB first in the byte right after the opcode, and is repeated for as long as clocking continues.
- R3: Opcode 0x06 sets the latch and opcode 0x04 clears it. Bit 1 of a status-write data byte has no effect on the latch.
- R4: Opcode 0x01 followed by one data byte loads the protect bits from data bits 3..2, provided the latch is set and the protect pin is high. That status write then clears the latch.
- R5: A status write made while the latch is clear, or while the protect pin is low, leaves every status bit unchanged, including the latch.
- R6: Opcode 0000_a011 reads memory and 0000_a010 writes memory. Bit a is address bit 8, and the next byte gives address bits 7..0. Each further data byte advances the address by one, and the address wraps from 0x1FF to 0x000.
- R7: A memory data byte is stored only when the latch is set, the protect pin is high and its address is not protected. Otherwise the stored byte keeps its old value.
- R8: The protect bits select the locked range: 00 locks nothing, 01 locks 0x180..0x1FF, 10 locks 0x100..0x1FF and 11 locks 0x000..0x1FF.
- R9: While the protect pin is low, no memory byte and no status bit can be written.
- R10: Raising chip select at the end of a memory write command clears the latch. This applies whether or not any byte was actually stored.
- R11: Raising chip select abandons any partly shifted command. Each chip select falling edge restarts the bit count at the opcode. An opcode outside the set above has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all SPI pins are oversampled with it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data into the block, MSB first |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| miso | output | 1 | Serial data out of the block, changes after falling serial clock edges |

## Verification
Every protect setting is tried with write bursts across three address windows: one straddling 0x100, one straddling 0x180 and one that wraps from 0x1FF into 0x000. Each window is read back byte by byte against a bench model. This tells an off-by-one range boundary apart from a wrong decode, and a broken address wrap apart from either. The status register is driven through each combination of latch state and protect pin, and is written with all-ones data, so that fixed bits, a latch bit forced by the data, and a silently accepted blocked write each show up. Truncated opcodes and unknown opcodes separate a bit counter that fails to restart from a decoder that reacts to stray codes.

// File: rtl/spiwp_pkg.sv
package spiwp_pkg;

  localparam int BYTE_W = 8;
  localparam int MEM_AW = 9;

  // command codes
  localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WRDI = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
  localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;

  // status byte field positions
  localparam int ST_WEL = 1;
  localparam int ST_BP0 = 2;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_RDAT,
    PH_WDAT,
    PH_SOUT,
    PH_SIN,
    PH_SKIP
  } phase_t;

  // memory access codes: 0000_a01x, x=1 read, x=0 write
  function automatic logic is_mem_op(input logic [BYTE_W-1:0] op);
    return (op[7:4] == 4'h0) && (op[2:1] == 2'b01);
  endfunction

endpackage

// File: rtl/spiwp_rst_sync.sv
module spiwp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = rst_q[STAGES-1];

endmodule

// File: rtl/spiwp_sync.sv
module spiwp_sync #(
  parameter int             N       = 4,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
      else        chain_q <= {chain_q[STAGES-2:0], d[i]};
    end

    assign q[i] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spiwp_status.sv
module spiwp_status
  import spiwp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_wel,
  input  logic              clr_wel,
  input  logic              ld_req,
  input  logic [1:0]        ld_bp,
  input  logic              wp_ok,
  output logic              wel,
  output logic [1:0]        bp,
  output logic [BYTE_W-1:0] stat_byte
);

  logic       wel_q, wel_n;
  logic [1:0] bp_q, bp_n;
  logic       ld_ok;
  logic       st_en;

  assign ld_ok = ld_req && wel_q && wp_ok;
  assign st_en = set_wel || clr_wel || ld_ok;

  always_comb begin
    wel_n = wel_q;
    bp_n  = bp_q;
    if (set_wel) begin
      wel_n = 1'b1;
    end else if (clr_wel) begin
      wel_n = 1'b0;
    end else if (ld_ok) begin
      bp_n  = ld_bp;
      wel_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      bp_q  <= 2'b00;
    end else if (st_en) begin
      wel_q <= wel_n;
      bp_q  <= bp_n;
    end
  end

  always_comb begin
    stat_byte              = '0;
    stat_byte[ST_WEL]      = wel_q;
    stat_byte[ST_BP0 +: 2] = bp_q;
  end

  assign wel = wel_q;
  assign bp  = bp_q;

  // R3: the latch only rises on an enable command
  a_r3_wel_rise_by_wren: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(set_wel));

  // R4: an accepted status write leaves the latch clear
  a_r4_wrsr_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_req && wel_q && wp_ok && !set_wel && !clr_wel) |-> !wel_q);

  // R5: protect bits move only through an accepted status write
  a_r5_bp_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_q != $past(bp_q)) |-> $past(ld_req && wel_q && wp_ok));

endmodule

// File: rtl/spiwp_guard.sv
module spiwp_guard #(
  parameter int AW = 9
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  input  logic          wel,
  input  logic          wp_ok,
  output logic          prot,
  output logic          permit
);

  localparam int DEPTH = 1 << AW;
  localparam int QTR_BASE  = DEPTH - DEPTH / 4;
  localparam int HALF_BASE = DEPTH / 2;

  logic [AW:0] lo_bound;

  always_comb begin
    case (bp)
      2'b00:   lo_bound = (AW+1)'(DEPTH);
      2'b01:   lo_bound = (AW+1)'(QTR_BASE);
      2'b10:   lo_bound = (AW+1)'(HALF_BASE);
      default: lo_bound = '0;
    endcase
  end

  assign prot   = ({1'b0, addr} >= lo_bound);
  assign permit = wel && wp_ok && !prot;

  // R8: locked range checked against the top address bits
  always_comb begin
    if (bp == 2'b00) a_r8_none_locked: assert (!prot);
    if (bp == 2'b01) a_r8_quarter: assert (prot == (&addr[AW-1:AW-2]));
    if (bp == 2'b10) a_r8_half: assert (prot == addr[AW-1]);
    if (bp == 2'b11) a_r8_all_locked: assert (prot);
    if (permit) a_r7_permit_needs_wel: assert (wel && wp_ok);
  end

endmodule

// File: rtl/spiwp_ram.sv
module spiwp_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/spiwp_ctrl.sv
module spiwp_ctrl
  import spiwp_pkg::*;
#(
  parameter int AW          = MEM_AW,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  input  logic wp_n,
  output logic miso
);

  localparam int DW    = BYTE_W;
  localparam int SH_W  = DW - 1;
  localparam int BIT_W = $clog2(DW);
  localparam int NPIN  = 4;

  // reset and pin synchronisation
  logic rst_s_n;

  spiwp_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  logic [NPIN-1:0] pins_raw, pins_s;
  assign pins_raw = {wp_n, mosi, sck, cs_n};

  spiwp_sync #(.N(NPIN), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  logic cs_s, sck_s, mosi_s, wp_s;
  assign cs_s   = pins_s[0];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[2];
  assign wp_s   = pins_s[3];

  logic sck_d, cs_d;
  logic sck_rise, sck_fall, cs_rise, cs_fall;

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s;
      cs_d  <= cs_s;
    end
  end

  assign sck_rise = sck_s && !sck_d;
  assign sck_fall = !sck_s && sck_d;
  assign cs_rise  = cs_s && !cs_d;
  assign cs_fall  = !cs_s && cs_d;

  // protocol state
  phase_t           ph_q, ph_n;
  logic [BIT_W-1:0] bcnt_q, bcnt_n;
  logic [SH_W-1:0]  sh_q, sh_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic             wcmd_q, wcmd_n;
  logic [DW-1:0]    tx_q, tx_n;
  logic             miso_q, miso_n;
  logic [DW-1:0]    rx_byte;

  assign rx_byte = {sh_q, mosi_s};

  // status, guard and array
  logic          set_wel, clr_wel, ld_req;
  logic [1:0]    ld_bp;
  logic          wel;
  logic [1:0]    bp;
  logic [DW-1:0] stat_byte;
  logic          prot, permit;
  logic          ram_we;
  logic [DW-1:0] ram_rdata;

  spiwp_status u_status (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .set_wel   (set_wel),
    .clr_wel   (clr_wel),
    .ld_req    (ld_req),
    .ld_bp     (ld_bp),
    .wp_ok     (wp_s),
    .wel       (wel),
    .bp        (bp),
    .stat_byte (stat_byte)
  );

  spiwp_guard #(.AW(AW)) u_guard (
    .bp     (bp),
    .addr   (addr_q),
    .wel    (wel),
    .wp_ok  (wp_s),
    .prot   (prot),
    .permit (permit)
  );

  spiwp_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (addr_q),
    .wdata (rx_byte),
    .raddr (addr_n),
    .rdata (ram_rdata)
  );

  // next-state
  always_comb begin
    ph_n    = ph_q;
    bcnt_n  = bcnt_q;
    sh_n    = sh_q;
    addr_n  = addr_q;
    wcmd_n  = wcmd_q;
    tx_n    = tx_q;
    miso_n  = miso_q;
    set_wel = 1'b0;
    clr_wel = 1'b0;
    ld_req  = 1'b0;
    ld_bp   = rx_byte[ST_BP0 +: 2];
    ram_we  = 1'b0;

    if (cs_s) begin
      ph_n   = PH_IDLE;
      bcnt_n = '0;
      wcmd_n = 1'b0;
      miso_n = 1'b0;
      if (cs_rise && wcmd_q) clr_wel = 1'b1;
    end else if (cs_fall) begin
      ph_n   = PH_OPC;
      bcnt_n = '0;
    end else if (sck_fall) begin
      miso_n = tx_q[DW-1];
      tx_n   = {tx_q[DW-2:0], 1'b0};
    end else if (sck_rise && (ph_q != PH_IDLE)) begin
      sh_n   = rx_byte[SH_W-1:0];
      bcnt_n = bcnt_q + 1'b1;
      if (bcnt_q == BIT_W'(DW-1)) begin
        case (ph_q)
          PH_OPC: begin
            ph_n = PH_SKIP;
            if (rx_byte == OP_WREN) begin
              set_wel = 1'b1;
            end else if (rx_byte == OP_WRDI) begin
              clr_wel = 1'b1;
            end else if (rx_byte == OP_RDSR) begin
              ph_n = PH_SOUT;
              tx_n = stat_byte;
            end else if (rx_byte == OP_WRSR) begin
              ph_n = PH_SIN;
            end else if (is_mem_op(rx_byte)) begin
              ph_n           = PH_ADDR;
              wcmd_n         = !rx_byte[0];
              addr_n[AW-1]   = rx_byte[3];
            end
          end
          PH_ADDR: begin
            addr_n = {addr_q[AW-1:DW], rx_byte};
            if (wcmd_q) begin
              ph_n = PH_WDAT;
            end else begin
              ph_n = PH_RDAT;
              tx_n = ram_rdata;
            end
          end
          PH_RDAT: begin
            addr_n = addr_q + 1'b1;
            tx_n   = ram_rdata;
          end
          PH_WDAT: begin
            ram_we = permit;
            addr_n = addr_q + 1'b1;
          end
          PH_SOUT: tx_n = stat_byte;
          PH_SIN: begin
            ld_req = 1'b1;
            ph_n   = PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ph_q   <= PH_IDLE;
      bcnt_q <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      wcmd_q <= 1'b0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      bcnt_q <= bcnt_n;
      sh_q   <= sh_n;
      addr_q <= addr_n;
      wcmd_q <= wcmd_n;
      tx_q   <= tx_n;
      miso_q <= miso_n;
    end
  end

  assign miso = miso_q;

  // R9: a low protect pin never lets a byte into the array
  a_r9_wp_blocks_commit: assert property (@(posedge clk) disable iff (!rst_s_n)
    !wp_s |-> !ram_we);

  // R7: a stored byte needs an armed latch
  a_r7_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_s_n)
    ram_we |-> (wel && !prot));

  // R11: deselect drops back to idle with a cleared bit count
  a_r11_cs_abort: assert property (@(posedge clk) disable iff (!rst_s_n)
    cs_rise |=> (ph_q == PH_IDLE && bcnt_q == '0));

  // R10: the end of a write command disarms the latch
  a_r10_wr_end_clears: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cs_rise && wcmd_q) |=> !wel);

  // R1: nothing is driven out while deselected
  a_r1_miso_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cs_s && cs_d) |-> !miso_q);

endmodule

// File: tb/tb_spiwp_ctrl.sv
module tb_spiwp_ctrl;

  localparam int H     = 6;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, mosi, wp_n;
  logic miso;

  always #2 clk = ~clk;

  spiwp_ctrl dut (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sck   (sck),
    .mosi  (mosi),
    .wp_n  (wp_n),
    .miso  (miso)
  );

  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;
  logic [7:0] model [DEPTH];
  int   wins [3] = '{'h0F8, 'h178, 'h1F8};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] o, output logic [7:0] i);
    for (int b = 7; b >= 0; b--) begin
      mosi = o[b];
      step(H);
      i[b] = miso;
      sck  = 1'b1;
      step(H);
      sck  = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    step(H);
  endtask

  task automatic desel();
    step(H);
    cs_n = 1'b1;
    step(2 * H);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] d;
    sel();
    xfer(op, d);
    desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel();
    xfer(8'h05, d);
    xfer(8'h00, s);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    sel();
    xfer(8'h01, d);
    xfer(v, d);
    desel();
  endtask

  function automatic logic [7:0] pat(input int a, input int r);
    return 8'((a * 13 + r * 41 + 7) & 255);
  endfunction

  // first locked address for a protect code (512 means none)
  function automatic int plo(input int bp);
    case (bp)
      0:       return DEPTH;
      1:       return DEPTH - DEPTH / 4;
      2:       return DEPTH / 2;
      default: return 0;
    endcase
  endfunction

  // lo: addresses below it are expected to be stored
  task automatic mwrite(input int a0, input int n, input int r, input int lo);
    logic [7:0] d;
    logic [8:0] a9;
    a9 = 9'(a0);
    sel();
    xfer({4'b0000, a9[8], 3'b010}, d);
    xfer(a9[7:0], d);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (a0 + k) % DEPTH;
      xfer(pat(a, r), d);
      if (a < lo) model[a] = pat(a, r);
    end
    desel();
  endtask

  task automatic mread(input int a0, input int n, input string req);
    logic [7:0] d;
    logic [8:0] a9;
    a9 = 9'(a0);
    sel();
    xfer({4'b0000, a9[8], 3'b011}, d);
    xfer(a9[7:0], d);
    for (int k = 0; k < n; k++) begin
      int a;
      a = (a0 + k) % DEPTH;
      xfer(8'h00, d);
      chk($sformatf("%s addr 0x%0h", req, a), d, model[a]);
    end
    desel();
  endtask

  initial begin
    logic [7:0] s;
    logic [7:0] d;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    sck   = 1'b0;
    mosi  = 1'b0;
    wp_n  = 1'b1;
    step(5);
    rst_n = 1'b1;
    step(8);

    chk("R1 miso while deselected", miso, 0);
    rdsr(s);
    chk("R1 status after reset", s, 8'h00);

    cmd(8'h06);
    rdsr(s);
    chk("R3 latch set by 0x06", s, 8'h02);
    cmd(8'h04);
    rdsr(s);
    chk("R3 latch cleared by 0x04", s, 8'h00);

    // R11: seven bits of an enable opcode, then deselect
    sel();
    for (int b = 7; b >= 1; b--) begin
      mosi = d[0];
      mosi = 1'((8'h06 >> b) & 1);
      step(H);
      sck = 1'b1;
      step(H);
      sck = 1'b0;
    end
    desel();
    rdsr(s);
    chk("R11 truncated opcode ignored", s, 8'h00);

    cmd(8'h06);
    cmd(8'h07);
    cmd(8'hA5);
    rdsr(s);
    chk("R11 unknown opcodes leave status", s, 8'h02);
    cmd(8'h04);

    wrsr(8'h0C);
    rdsr(s);
    chk("R5 status write without latch", s, 8'h00);

    cmd(8'h06);
    wp_n = 1'b0;
    wrsr(8'h0C);
    rdsr(s);
    chk("R5 R9 status write with pin low", s, 8'h02);
    wp_n = 1'b1;

    wrsr(8'hFF);
    rdsr(s);
    chk("R2 fixed bits read zero", int'(s & 8'hF1), 0);
    chk("R3 R4 all-ones write gives BP=11 and clear latch", s, 8'h0C);
    cmd(8'h06);
    wrsr(8'h00);
    rdsr(s);
    chk("R4 protect bits cleared", s, 8'h00);

    // seed windows with no protection
    for (int w = 0; w < 3; w++) begin
      cmd(8'h06);
      mwrite(wins[w], 16, 0, plo(0));
      rdsr(s);
      chk("R10 latch cleared after write command", s, 8'h00);
      mread(wins[w], 16, "R6 R7 unprotected burst");
    end

    for (int bp = 1; bp < 4; bp++) begin
      cmd(8'h06);
      wrsr(8'(bp << 2));
      rdsr(s);
      chk("R4 protect bits loaded", s, bp << 2);
      for (int w = 0; w < 3; w++) begin
        cmd(8'h06);
        mwrite(wins[w], 16, bp, plo(bp));
        mread(wins[w], 16, $sformatf("R8 protect code %0d", bp));
      end
    end

    cmd(8'h06);
    wp_n = 1'b1;
    wrsr(8'h00);
    rdsr(s);
    chk("R4 protect bits restored to 00", s, 8'h00);

    mwrite(wins[0], 16, 7, 0);
    mread(wins[0], 16, "R7 write with latch clear");

    cmd(8'h06);
    wp_n = 1'b0;
    mwrite(wins[1], 16, 8, 0);
    wp_n = 1'b1;
    mread(wins[1], 16, "R9 write with pin low");
    rdsr(s);
    chk("R10 latch cleared after blocked write", s, 8'h00);

    cmd(8'h06);
    mwrite(wins[2], 16, 9, plo(0));
    mread(wins[2], 16, "R6 R7 wrapped burst after re-arm");

    // R2: status repeats while clocking continues
    sel();
    xfer(8'h05, d);
    xfer(8'h00, s);
    xfer(8'h00, d);
    desel();
    chk("R2 status repeated", d, s);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=stalled expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule